// File: doc/BRIEF.md
# Multicast Head-of-Line Launch Controller

This block sits at the front of one input queue of a crosspoint-buffered switch. Each cell slot it looks at the head cell, which carries a destination bitmap with one bit per output. It raises a request line toward every crosspoint in its row whose bit is set. It then listens for refusals during a fixed window of clock cycles. If no requested crosspoint refuses, the cell is launched to all its destinations in the same cycle and popped from the queue. If even one crosspoint refuses, the cell goes nowhere and is offered again in the next slot.

A crosspoint that is still holding an earlier cell from this input refuses a new request. Because of that, the head cell never reaches a busy crosspoint, and cells from one input leave in order. A unicast cell is simply a bitmap with a single bit set. A head cell whose bitmap is all zero cannot go anywhere, so it is popped at once and flagged.

The slot is `SLOT_CYC` clock cycles long and restarts on its own after reset. Slot position 0 is the slot start, positions 1 to `WIN_CYC` form the request window, and position `WIN_CYC`+1 carries the launch strobe. `SLOT_CYC` must be at least `WIN_CYC`+2.

The head-cell input follows valid/ready rules. Once `hd_valid` is high, `hd_map` and `hd_data` must hold steady until `hd_ready` is seen high on a clock edge. `hd_ready` only rises while `hd_valid` is high, and it stays low through any number of refused slots, which is how the controller applies back-pressure. The launch side is a strobe bus with no ready: a crosspoint that could not take the cell has already refused it during the window.

Top module: `hol_mcast_launch`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_o`, `launch_o`, `err_o` and `hd_ready` are all zero.
- R2: When a slot starts with a valid head cell that has a non-zero bitmap, `req_o` equals that bitmap in slot positions 1 to `WIN_CYC`. In every other position `req_o` is zero.
- R3: A bitmap with exactly one bit set raises exactly that one request line and that one launch line. No other line is touched.
- R4: If any requested line sees `nack_i` high in any window position, no launch line pulses in that slot and `hd_ready` stays low for the whole slot.
- R5: A refused cell is requested again, with the same bitmap, starting at position 1 of the very next slot.
- R6: If no requested line is refused, `launch_o` equals the bitmap for exactly one cycle, at slot position `WIN_CYC`+1. In that same cycle `cell_o` carries the head cell's `hd_data`.
- R7: `hd_ready` is high for exactly one cycle per accepted cell, and only while `hd_valid` is high. For a launched cell that cycle is the last window position, `WIN_CYC`.
- R8: A `nack_i` bit whose position is zero in the current bitmap has no effect on the launch.
- R9: A `nack_i` bit seen outside positions 1 to `WIN_CYC` has no effect. A `nack_i` bit seen in position 1 or in position `WIN_CYC` blocks the launch.
- R10: A valid head cell whose bitmap is all zero is popped, with `hd_ready` high in slot position 0. `err_o` then pulses high for one cycle in position 1. No request and no launch line rises for that cell.
- R11: A slot that starts with `hd_valid` low produces no request, no launch, no pop and no error.
- R12: Every launch pattern equals the request pattern of the cycle just before it. Cells leave in the order they were popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_valid | input | 1 | Head cell present |
| hd_ready | output | 1 | Head cell accepted (pop) |
| hd_map | input | N_OUT | Destination bitmap of the head cell, bit i selects output i |
| hd_data | input | DATA_W | Head cell payload |
| req_o | output | N_OUT | Request line per crosspoint in this row |
| nack_i | input | N_OUT | Refusal line per crosspoint in this row |
| launch_o | output | N_OUT | One-cycle launch strobe per crosspoint |
| cell_o | output | DATA_W | Cell payload shared by all launch strobes |
| err_o | output | 1 | One-cycle pulse: all-zero bitmap dropped |

## Verification
The bench builds the block with four outputs, 16-bit cells, a three-cycle window and an eight-cycle slot. With four outputs, unicast, partial multicast and full broadcast patterns can all be tried, and refusals can land on requested lines or on unrequested ones. The three-cycle window has separate first, middle and last positions, and the eight-cycle slot leaves quiet positions on both sides of the window. Together these let refusals be placed just inside and just outside the window edges.

// File: rtl/hol_pkg.sv
package hol_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_ASK  = 1'b1
  } hol_phase_e;
endpackage

// File: rtl/hol_slot_timer.sv
module hol_slot_timer #(
  parameter int SLOT_CYC = 8,
  parameter int WIN_CYC  = 3
) (
  input  logic clk,
  input  logic rst,
  output logic slot_start,
  output logic win_on,
  output logic win_last
);
  localparam int CNT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] WIN_BEG  = CNT_W'(1);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)                   pos_q <= '0;
    else if (pos_q == LAST_POS) pos_q <= '0;
    else                       pos_q <= pos_q + WIN_BEG;
  end

  assign slot_start = (pos_q == '0);
  assign win_on     = (pos_q >= WIN_BEG) && (pos_q <= WIN_END);
  assign win_last   = (pos_q == WIN_END);

  // R5: slot boundaries are isolated single cycles
  assert_slot_period_R5: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> !slot_start);
endmodule

// File: rtl/hol_req_window.sv
module hol_req_window
  import hol_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_OUT-1:0] map,
  input  logic             win_on,
  input  logic             win_last,
  input  logic [N_OUT-1:0] nack_i,
  output logic [N_OUT-1:0] req_o,
  output logic             nack_hit,
  output logic             clear
);
  hol_phase_e       phase_q;
  logic [N_OUT-1:0] req_q;
  logic             seen_q;
  logic             asking;
  logic             cur_hit;

  assign asking   = (phase_q == PH_ASK) && win_on;
  assign cur_hit  = asking && (|(nack_i & req_q));
  assign nack_hit = seen_q | cur_hit;
  assign clear    = asking && win_last && !nack_hit;
  assign req_o    = asking ? req_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      req_q   <= '0;
      seen_q  <= 1'b0;
    end else if (start) begin
      phase_q <= PH_ASK;
      req_q   <= map;
      seen_q  <= 1'b0;
    end else if (asking) begin
      seen_q <= nack_hit;
      if (win_last) phase_q <= PH_IDLE;
    end
  end

  // R2: the request pattern does not change inside one window
  assert_req_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (asking && $past(asking) && !$past(win_last)) |-> $stable(req_o));
endmodule

// File: rtl/hol_launch_stage.sv
module hol_launch_stage #(
  parameter int N_OUT  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              drop,
  input  logic [N_OUT-1:0]  map,
  input  logic [DATA_W-1:0] data,
  output logic [N_OUT-1:0]  launch_o,
  output logic [DATA_W-1:0] cell_o,
  output logic              err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      launch_o <= '0;
      cell_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      launch_o <= go ? map : '0;
      err_o    <= drop;
      if (go) cell_o <= data;
    end
  end

  // R6: a launch strobe lasts a single cycle
  assert_launch_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (|launch_o) |=> (launch_o == '0));
endmodule

// File: rtl/hol_mcast_launch.sv
module hol_mcast_launch #(
  parameter int N_OUT    = 4,
  parameter int DATA_W   = 16,
  parameter int WIN_CYC  = 3,
  parameter int SLOT_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hd_valid,
  output logic              hd_ready,
  input  logic [N_OUT-1:0]  hd_map,
  input  logic [DATA_W-1:0] hd_data,
  output logic [N_OUT-1:0]  req_o,
  input  logic [N_OUT-1:0]  nack_i,
  output logic [N_OUT-1:0]  launch_o,
  output logic [DATA_W-1:0] cell_o,
  output logic              err_o
);
  logic slot_start, win_on, win_last;
  logic start, drop, clear, nack_hit;

  hol_slot_timer #(.SLOT_CYC(SLOT_CYC), .WIN_CYC(WIN_CYC)) u_timer (
    .clk(clk), .rst(rst), .slot_start(slot_start),
    .win_on(win_on), .win_last(win_last)
  );

  assign start = slot_start && hd_valid && (|hd_map);
  assign drop  = slot_start && hd_valid && (hd_map == '0);

  hol_req_window #(.N_OUT(N_OUT)) u_req (
    .clk(clk), .rst(rst), .start(start), .map(hd_map),
    .win_on(win_on), .win_last(win_last), .nack_i(nack_i),
    .req_o(req_o), .nack_hit(nack_hit), .clear(clear)
  );

  hol_launch_stage #(.N_OUT(N_OUT), .DATA_W(DATA_W)) u_launch (
    .clk(clk), .rst(rst), .go(clear), .drop(drop), .map(req_o),
    .data(hd_data), .launch_o(launch_o), .cell_o(cell_o), .err_o(err_o)
  );

  assign hd_ready = drop || clear;

  assert_pop_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    hd_ready |-> hd_valid);
  assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
    hd_ready |=> !hd_ready);
  assert_launch_matches_req_R12: assert property (@(posedge clk) disable iff (rst)
    (|launch_o) |-> (launch_o == $past(req_o)));
  assert_no_launch_after_nack_R4: assert property (@(posedge clk) disable iff (rst)
    (|launch_o) |-> !$past(nack_hit));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (req_o == '0 && launch_o == '0));
  assert_no_req_at_start_R2: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> (req_o == '0));
endmodule

// File: tb/hol_mcast_launch_tb.sv
`timescale 1ns/1ps
module hol_mcast_launch_tb;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int WN = 3;
  localparam int SL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hd_valid = 1'b0;
  logic          hd_ready;
  logic [N-1:0]  hd_map = '0;
  logic [DW-1:0] hd_data = '0;
  logic [N-1:0]  req_o;
  logic [N-1:0]  nack_i = '0;
  logic [N-1:0]  launch_o;
  logic [DW-1:0] cell_o;
  logic          err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [N+DW-1:0] expq[$];

  always #2.5 clk = ~clk;

  hol_mcast_launch #(.N_OUT(N), .DATA_W(DW), .WIN_CYC(WN), .SLOT_CYC(SL)) u_dut (
    .clk(clk), .rst(rst), .hd_valid(hd_valid), .hd_ready(hd_ready),
    .hd_map(hd_map), .hd_data(hd_data), .req_o(req_o), .nack_i(nack_i),
    .launch_o(launch_o), .cell_o(cell_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // scoreboard monitor (R6, R12): each launch must match the next queued cell
  always @(negedge clk) begin
    #1;
    if (!rst && (|launch_o)) begin
      if (expq.size() == 0)
        chk(1'b0, "R12 unexpected launch", {28'd0, launch_o}, 32'd0);
      else begin
        logic [N+DW-1:0] e;
        e = expq.pop_front();
        chk({launch_o, cell_o} == e, "R12 launch/cell vs scoreboard",
            {{(32-N-DW){1'b0}}, launch_o, cell_o}, {{(32-N-DW){1'b0}}, e});
      end
    end
  end

  // one slot, entered mid-cycle at slot position 0; one refusal cycle nk_at (-1 = none)
  task automatic run_slot(input string scen, input bit v, input logic [N-1:0] m,
                          input logic [DW-1:0] d, input int nk_at, input logic [N-1:0] nk_mask);
    bit hit;
    hit = v && (m != '0) && (nk_at >= 1) && (nk_at <= WN) && (|(nk_mask & m));
    hd_valid = v; hd_map = m; hd_data = d;
    for (int k = 0; k < SL; k++) begin
      logic [N-1:0] e_req, e_lau;
      bit e_rdy, e_err;
      nack_i = (k == nk_at) ? nk_mask : '0;
      #1;
      e_req = (v && m != '0 && k >= 1 && k <= WN) ? m : '0;
      e_lau = (v && m != '0 && !hit && k == WN + 1) ? m : '0;
      e_rdy = (v && m == '0 && k == 0) || (v && m != '0 && !hit && k == WN);
      e_err = v && (m == '0) && (k == 1);
      chk(req_o == e_req, {scen, " R2 req_o"}, {28'd0, req_o}, {28'd0, e_req});
      chk(launch_o == e_lau, {scen, hit ? " R4 launch blocked" : " R6 launch_o"},
          {28'd0, launch_o}, {28'd0, e_lau});
      chk(hd_ready == e_rdy, {scen, " R7 hd_ready"}, {31'd0, hd_ready}, {31'd0, e_rdy});
      chk(err_o == e_err, {scen, " R10 err_o"}, {31'd0, err_o}, {31'd0, e_err});
      if (e_rdy && m != '0) expq.push_back({m, d});
      @(negedge clk);
    end
    nack_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk(req_o == '0 && launch_o == '0 && !err_o && !hd_ready, "R1 reset outputs",
        {26'd0, req_o, launch_o[0], err_o, hd_ready}, 32'd0);
    rst = 1'b0;
    #1;
    chk(req_o == '0 && launch_o == '0 && !err_o && !hd_ready, "R1 first cycle after reset",
        {26'd0, req_o, launch_o[0], err_o, hd_ready}, 32'd0);
    @(negedge clk);
    // we are now one cycle into slot 0; idle through the rest of it
    repeat (SL - 1) @(negedge clk);

    run_slot("R11 idle",            1'b0, 4'b0000, 16'h0000, -1, 4'b0000);
    run_slot("R6 multicast",        1'b1, 4'b1011, 16'hA5A5, -1, 4'b0000);
    run_slot("R3 unicast",          1'b1, 4'b0100, 16'h1234, -1, 4'b0000);
    run_slot("R6 broadcast",        1'b1, 4'b1111, 16'hBEEF, -1, 4'b0000);
    run_slot("R4 refused mid",      1'b1, 4'b0110, 16'h0F0F,  2, 4'b0010);
    run_slot("R5 retry refused",    1'b1, 4'b0110, 16'h0F0F,  1, 4'b0100);
    run_slot("R5 retry clean",      1'b1, 4'b0110, 16'h0F0F, -1, 4'b0000);
    run_slot("R9 refused last pos", 1'b1, 4'b1001, 16'h5555,  WN, 4'b1000);
    run_slot("R9 outside before",   1'b1, 4'b1001, 16'h5555,  0, 4'b1111);
    run_slot("R9 outside after",    1'b1, 4'b0011, 16'h6666,  WN + 1, 4'b1111);
    run_slot("R8 unrequested nack", 1'b1, 4'b0101, 16'h7777,  2, 4'b1010);
    run_slot("R10 zero map",        1'b1, 4'b0000, 16'hDEAD, -1, 4'b0000);
    run_slot("R3 unicast high",     1'b1, 4'b1000, 16'hC0DE,  1, 4'b0111);
    run_slot("R11 idle after",      1'b0, 4'b0000, 16'h0000, -1, 4'b0000);

    chk(expq.size() == 0, "R12 scoreboard drained", expq.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule